// File: doc/BRIEF.md
# Mapped Interrupt Dispatch Controller

This block gathers 64 level-sensitive interrupt lines and presents at most one of them at a time on a 64-bit one-hot vector output. The lower 32 lines come from expansion-bus slots, four lines per slot. The four lines of a slot share one mapping register. The upper 32 lines come from on-board sources, and each has a mapping register of its own. The top bit of a mapping register is the line's enable. The remaining 31 bits hold a fixed routing code that software can read but cannot change.

Once a request has been raised, the block keeps driving it until software withdraws it. Software does this either by writing a clear register or by disabling the mapping register that covers the line. Only after that does the block rescan the pending lines. The rescan uses a fixed order: slot lines first, lowest index first, then on-board lines. A simple valid/write register bus gives software access to the mapping and clear registers. Each register spans 8 bytes, and only the upper word of each 8-byte pair (byte offset +4) responds.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: A synchronous reset drives `vec_out` to zero, clears every enable bit, forgets all pending lines and discards the outstanding request. The fixed routing bits of the mapping registers are unaffected.
- R2: A read of a mapping register at its +4 word returns {enable, routing code} one cycle later. The routing code is 0x7C0 | (k<<2) for slot register k at 0x0C04+8k, and 0x7E0 + j for on-board register j at 0x1004+8j. Reads of the +0 word and of clear registers return 0, and writes to the +0 word change nothing.
- R3: A write to a mapping register changes only bit 31 (the enable). Bits 30:0 keep their routing code whatever the write data holds.
- R4: `vec_out` is zero or one-hot, and it never shows a line whose mapping register is disabled.
- R5: A slot line (index 0 to 31) that rises while its slot is enabled becomes the request at the next clock edge, even if another request is outstanding.
- R6: An on-board line (index 32 to 63) that rises is accepted only if it is enabled and no request is outstanding. Otherwise it only becomes pending.
- R7: An outstanding request stays on `vec_out` through rescans and through higher-priority pending lines until it is withdrawn.
- R8: A rescan happens one edge after the triggering write. When nothing is outstanding, it selects the lowest-index line that is both pending and enabled, so slot lines always come before on-board lines. A rescan follows every mapping write and every clear that drops the request.
- R9: Writing 0 to bit 31 of the mapping register covering the outstanding line drops that line from `vec_out` at the write edge.
- R10: A write to slot clear register s at 0x1404+32s (slot taken from address bits 7:5) drops the request at the write edge only when the request index divided by 4 equals s.
- R11: A write to on-board clear register j at 0x1804+8j (line 32+j taken from address bits 7:3) drops the request only if line 32+j itself is outstanding.
- R12: A falling input only clears its pending state. An outstanding request from that line remains on `vec_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level interrupt lines, slot lines in 31:0, on-board lines in 63:32 |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Write data, bit 31 is the enable |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| vec_out | output | 64 | One-hot outstanding request, or zero |

## Verification
The bench raises a lower-priority on-board request and then enables a slot with a pending line. A controller that let the higher-priority line pre-empt the request would move `vec_out` at that point instead of holding it. It sends clears that name the wrong slot or the wrong on-board line, where decoding the slot from the wrong address bits or comparing whole indices would drop the request too early. It clears a request whose input is still high, so a controller that forgot level inputs would go quiet instead of re-raising the same line. It also checks that an on-board rise is refused while another request is outstanding, and that a slot rise is accepted in the same situation.

// File: rtl/idc_pkg.sv
package idc_pkg;

  // Register window bases, byte addresses
  localparam int unsigned PCI_MAP_BASE   = 32'h0C00;
  localparam int unsigned OB_MAP_BASE    = 32'h1000;
  localparam int unsigned PCI_CLR_BASE   = 32'h1400;
  localparam int unsigned OB_CLR_BASE    = 32'h1800;

  // Each register spans 8 bytes; slot clears are spaced 32 bytes apart
  localparam int unsigned REG_STRIDE_SH  = 3;
  localparam int unsigned SLOT_STRIDE_SH = 5;

  // Fixed routing code fields held in bits 30:0 of the mapping registers
  localparam int unsigned PRIO_CODE      = 32'h1F;
  localparam int unsigned PRIO_SH        = 6;
  localparam int unsigned OB_CODE        = 32'h20;

  typedef struct packed {
    logic map_pci;
    logic map_ob;
    logic clr_pci;
    logic clr_ob;
  } idc_hit_t;

  function automatic logic [31:0] pci_fixed(input int unsigned k);
    return (PRIO_CODE << PRIO_SH) | (k << 2);
  endfunction

  function automatic logic [31:0] ob_fixed(input int unsigned j);
    return ((PRIO_CODE << PRIO_SH) | OB_CODE) + j;
  endfunction

endpackage

// File: rtl/idc_bus_decode.sv
module idc_bus_decode
  import idc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int N_PCI_GRP = 8,
  parameter int N_OB      = 32,
  parameter int SEL_W     = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output idc_hit_t          hit,
  output logic [SEL_W-1:0]  sel
);

  localparam int unsigned PCI_MAP_SPAN = N_PCI_GRP << REG_STRIDE_SH;
  localparam int unsigned OB_MAP_SPAN  = N_OB << REG_STRIDE_SH;
  localparam int unsigned PCI_CLR_SPAN = N_PCI_GRP << SLOT_STRIDE_SH;
  localparam int unsigned OB_CLR_SPAN  = N_OB << REG_STRIDE_SH;

  logic [31:0] a;
  logic [31:0] off_pm, off_om, off_pc, off_oc;

  assign a = 32'(addr);

  always_comb begin
    off_pm = a - PCI_MAP_BASE;
    off_om = a - OB_MAP_BASE;
    off_pc = a - PCI_CLR_BASE;
    off_oc = a - OB_CLR_BASE;

    // Only the upper word of each 8-byte register responds
    hit.map_pci = a[2] && (a >= PCI_MAP_BASE) && (a < PCI_MAP_BASE + PCI_MAP_SPAN);
    hit.map_ob  = a[2] && (a >= OB_MAP_BASE)  && (a < OB_MAP_BASE + OB_MAP_SPAN);
    hit.clr_pci = a[2] && (a >= PCI_CLR_BASE) && (a < PCI_CLR_BASE + PCI_CLR_SPAN);
    hit.clr_ob  = a[2] && (a >= OB_CLR_BASE)  && (a < OB_CLR_BASE + OB_CLR_SPAN);

    sel = '0;
    if (hit.map_pci)      sel = SEL_W'(off_pm >> REG_STRIDE_SH);
    else if (hit.map_ob)  sel = SEL_W'(off_om >> REG_STRIDE_SH);
    else if (hit.clr_pci) sel = SEL_W'(off_pc >> SLOT_STRIDE_SH);
    else if (hit.clr_ob)  sel = SEL_W'(off_oc >> REG_STRIDE_SH);
  end

endmodule

// File: rtl/idc_map_regs.sv
module idc_map_regs
  import idc_pkg::*;
#(
  parameter int N_PCI_GRP = 8,
  parameter int N_OB      = 32,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_pci,
  input  logic                 wr_ob,
  input  logic                 rd_pci,
  input  logic                 rd_ob,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 en_val,
  output logic [N_PCI_GRP-1:0] en_pci,
  output logic [N_OB-1:0]      en_ob,
  output logic [DATA_W-1:0]    rdata
);

  localparam int PG_W = (N_PCI_GRP > 1) ? $clog2(N_PCI_GRP) : 1;
  localparam int OB_W = (N_OB > 1) ? $clog2(N_OB) : 1;

  logic [31:0]       fx;
  logic [DATA_W-1:0] rd_val;

  // Only the enable bit is stored; the routing code is a constant per register
  always_ff @(posedge clk) begin
    if (rst) begin
      en_pci <= '0;
      en_ob  <= '0;
    end else begin
      for (int k = 0; k < N_PCI_GRP; k++)
        if (wr_pci && (sel == SEL_W'(k))) en_pci[k] <= en_val;
      for (int j = 0; j < N_OB; j++)
        if (wr_ob && (sel == SEL_W'(j))) en_ob[j] <= en_val;
    end
  end

  always_comb begin
    fx     = '0;
    rd_val = '0;
    if (rd_pci) begin
      fx     = pci_fixed(int'(sel[PG_W-1:0]));
      rd_val = {en_pci[sel[PG_W-1:0]], fx[DATA_W-2:0]};
    end else if (rd_ob) begin
      fx     = ob_fixed(int'(sel[OB_W-1:0]));
      rd_val = {en_ob[sel[OB_W-1:0]], fx[DATA_W-2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_val;
  end

endmodule

// File: rtl/idc_first_set.sv
module idc_first_set #(
  parameter int W     = 64,
  parameter int IDX_W = 6
) (
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import idc_pkg::*;
#(
  parameter int N_PCI_GRP = 8,
  parameter int GRP_SZ    = 4,
  parameter int N_OB      = 32,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [N_PCI_GRP*GRP_SZ+N_OB-1:0]    irq_in,
  input  logic                                bus_valid,
  input  logic                                bus_write,
  input  logic [ADDR_W-1:0]                   bus_addr,
  input  logic [DATA_W-1:0]                   bus_wdata,
  output logic [DATA_W-1:0]                   bus_rdata,
  output logic [N_PCI_GRP*GRP_SZ+N_OB-1:0]    vec_out
);

  localparam int N_PCI  = N_PCI_GRP * GRP_SZ;
  localparam int N_IN   = N_PCI + N_OB;
  localparam int IDX_W  = $clog2(N_IN);
  localparam int GRP_W  = $clog2(GRP_SZ);
  localparam int PG_W   = (N_PCI_GRP > 1) ? $clog2(N_PCI_GRP) : 1;
  localparam int OB_W   = (N_OB > 1) ? $clog2(N_OB) : 1;
  localparam int PCI_IW = $clog2(N_PCI);
  localparam int SEL_W  = (PG_W > OB_W) ? PG_W : OB_W;

  idc_hit_t          hit;
  logic [SEL_W-1:0]  sel;
  logic              wr, rd;
  logic [N_PCI_GRP-1:0] en_pci;
  logic [N_OB-1:0]   en_ob;
  logic [N_IN-1:0]   en_line;
  logic [N_IN-1:0]   pend_q;
  logic [N_IN-1:0]   rise;

  logic              req_v_q, scan_q;
  logic [IDX_W-1:0]  req_i_q;
  logic              nv, scan_d, drop;
  logic [IDX_W-1:0]  ni;
  logic [PG_W-1:0]   ngrp;
  logic [N_IN-1:0]   vec_d;

  logic              scan_found, rpci_found, rob_found;
  logic [IDX_W-1:0]  scan_idx;
  logic [PCI_IW-1:0] rpci_idx;
  logic [OB_W-1:0]   rob_idx;

  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;

  idc_bus_decode #(
    .ADDR_W(ADDR_W), .N_PCI_GRP(N_PCI_GRP), .N_OB(N_OB), .SEL_W(SEL_W)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .sel(sel)
  );

  idc_map_regs #(
    .N_PCI_GRP(N_PCI_GRP), .N_OB(N_OB), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_pci(wr & hit.map_pci), .wr_ob(wr & hit.map_ob),
    .rd_pci(rd & hit.map_pci), .rd_ob(rd & hit.map_ob),
    .sel(sel), .en_val(bus_wdata[DATA_W-1]),
    .en_pci(en_pci), .en_ob(en_ob), .rdata(bus_rdata)
  );

  // Spread the register enables over the lines they govern
  for (genvar i = 0; i < N_PCI; i++) begin : g_pci_en
    assign en_line[i] = en_pci[i/GRP_SZ];
  end
  for (genvar j = 0; j < N_OB; j++) begin : g_ob_en
    assign en_line[N_PCI+j] = en_ob[j];
  end

  assign rise = irq_in & ~pend_q;

  idc_first_set #(.W(N_IN), .IDX_W(IDX_W)) u_scan (
    .vec(pend_q & en_line), .found(scan_found), .idx(scan_idx)
  );
  idc_first_set #(.W(N_PCI), .IDX_W(PCI_IW)) u_rise_pci (
    .vec(rise[N_PCI-1:0] & en_line[N_PCI-1:0]), .found(rpci_found), .idx(rpci_idx)
  );
  idc_first_set #(.W(N_OB), .IDX_W(OB_W)) u_rise_ob (
    .vec(rise[N_IN-1:N_PCI] & en_line[N_IN-1:N_PCI]), .found(rob_found), .idx(rob_idx)
  );

  always_comb begin
    nv = req_v_q;
    ni = req_i_q;

    // Deferred rescan, only when nothing is outstanding
    if (scan_q && !nv && scan_found) begin
      nv = 1'b1;
      ni = scan_idx;
    end

    // Slot rises take over at once; on-board rises only into an empty slot
    if (rpci_found) begin
      nv = 1'b1;
      ni = IDX_W'(rpci_idx);
    end else if (!nv && rob_found) begin
      nv = 1'b1;
      ni = IDX_W'(N_PCI) + IDX_W'(rob_idx);
    end

    ngrp = ni[GRP_W +: PG_W];
    drop = 1'b0;
    if (wr && nv) begin
      if (hit.map_pci && !bus_wdata[DATA_W-1] && (ni < IDX_W'(N_PCI)) &&
          (ngrp == sel[PG_W-1:0]))
        drop = 1'b1;
      if (hit.map_ob && !bus_wdata[DATA_W-1] && (ni == IDX_W'(N_PCI) + IDX_W'(sel)))
        drop = 1'b1;
      if (hit.clr_pci && (ni < IDX_W'(N_PCI)) && (ngrp == sel[PG_W-1:0]))
        drop = 1'b1;
      if (hit.clr_ob && (ni == IDX_W'(N_PCI) + IDX_W'(sel)))
        drop = 1'b1;
    end
    if (drop) nv = 1'b0;

    scan_d = drop | (wr & (hit.map_pci | hit.map_ob));

    vec_d = '0;
    if (nv) vec_d[ni] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_v_q <= 1'b0;
      req_i_q <= '0;
      scan_q  <= 1'b0;
      pend_q  <= '0;
      vec_out <= '0;
    end else begin
      req_v_q <= nv;
      req_i_q <= ni;
      scan_q  <= scan_d;
      pend_q  <= irq_in;
      vec_out <= vec_d;
    end
  end

endmodule

// File: rtl/idc_checker.sv
module idc_checker
  import idc_pkg::*;
#(
  parameter int N_PCI_GRP = 8,
  parameter int GRP_SZ    = 4,
  parameter int N_OB      = 32,
  parameter int ADDR_W    = 16
) (
  input logic                             clk,
  input logic                             rst,
  input logic [N_PCI_GRP*GRP_SZ+N_OB-1:0] irq_in,
  input logic                             bus_valid,
  input logic                             bus_write,
  input logic [ADDR_W-1:0]                bus_addr,
  input logic [N_PCI_GRP*GRP_SZ+N_OB-1:0] vec_out,
  input logic [N_PCI_GRP*GRP_SZ+N_OB-1:0] en_line
);

  localparam int N_PCI = N_PCI_GRP * GRP_SZ;
  localparam int N_IN  = N_PCI + N_OB;

  logic [31:0]     a;
  logic            clr_hit;
  logic [N_IN-1:0] grp_mask;

  assign a = 32'(bus_addr);

  always_comb begin
    clr_hit  = a[2] && (a >= PCI_CLR_BASE) &&
               (a < PCI_CLR_BASE + (N_PCI_GRP << SLOT_STRIDE_SH));
    grp_mask = '0;
    if (clr_hit)
      for (int i = 0; i < N_PCI; i++)
        if ((i / GRP_SZ) == int'((a - PCI_CLR_BASE) >> SLOT_STRIDE_SH))
          grp_mask[i] = 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (vec_out == '0));

  p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vec_out));

  p_gated_r4: assert property (@(posedge clk) disable iff (rst)
    ((vec_out & ~en_line) == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (vec_out != '0) && !(bus_valid && bus_write) &&
     ((irq_in & ~$past(irq_in)) == '0))
    |=> (vec_out == $past(vec_out)));

  p_slot_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && clr_hit) |=> ((vec_out & $past(grp_mask)) == '0));

endmodule

bind irq_dispatch_ctrl idc_checker #(
  .N_PCI_GRP(N_PCI_GRP), .GRP_SZ(GRP_SZ), .N_OB(N_OB), .ADDR_W(ADDR_W)
) u_idc_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .vec_out(vec_out),
  .en_line(en_line)
);

// File: tb/irq_dispatch_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_dispatch_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] vec_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Reference model: enables and pending levels per line
  logic [63:0] m_en = '0;
  logic [63:0] m_pend = '0;

  always #2.5 clk = ~clk;

  irq_dispatch_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .vec_out(vec_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] m_pick();
    for (int i = 0; i < 64; i++)
      if (m_pend[i] && m_en[i]) return 64'd1 << i;
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 16'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 16'(a);
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic map_pci(input int k, input bit e);
    bus_wr(32'h0C04 + k*8, e ? 32'h8000_0000 : 32'h0);
    for (int i = 0; i < 4; i++) m_en[k*4+i] = e;
  endtask

  task automatic map_ob(input int j, input bit e);
    bus_wr(32'h1004 + j*8, e ? 32'h8000_0000 : 32'h0);
    m_en[32+j] = e;
  endtask

  task automatic clr_pci(input int s);
    bus_wr(32'h1404 + s*32, 32'h0);
  endtask

  task automatic clr_ob(input int j);
    bus_wr(32'h1804 + j*8, 32'h0);
  endtask

  task automatic set_irq(input int i, input bit v);
    irq_in[i] = v;
    m_pend[i] = v;
    @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk("R1 vec after reset", vec_out, '0);
    bus_rd(32'h0C1C, d); chk("R2 slot3 read", 64'(d), 64'h7CC);
    bus_rd(32'h102C, d); chk("R2 onboard5 read", 64'(d), 64'h7E5);
  endtask

  task automatic t_reg_access();
    logic [31:0] d;
    bus_rd(32'h0C18, d); chk("R2 low word reads zero", 64'(d), '0);
    bus_wr(32'h0C18, 32'hFFFF_FFFF); idle();
    bus_rd(32'h0C1C, d); chk("R2 low word write ignored", 64'(d), 64'h7CC);
    bus_wr(32'h0C1C, 32'hFFFF_FFFF); idle();
    bus_rd(32'h0C1C, d); chk("R3 only enable changes", 64'(d), 64'h8000_07CC);
    bus_wr(32'h0C1C, 32'h0); idle();
    bus_rd(32'h0C1C, d); chk("R3 enable cleared", 64'(d), 64'h7CC);
    bus_rd(32'h1404, d); chk("R2 clear reg reads zero", 64'(d), '0);
  endtask

  task automatic t_gating();
    set_irq(9, 1);  chk("R4 disabled slot line", vec_out, '0);
    set_irq(33, 1); chk("R4 disabled onboard 33", vec_out, '0);
    set_irq(40, 1); chk("R4 disabled onboard 40", vec_out, '0);
  endtask

  task automatic t_rescan_hold();
    map_ob(1, 1); idle();
    chk("R8 rescan picks onboard 33", vec_out, m_pick());
    map_pci(2, 1); idle();
    chk("R7 outstanding 33 held over slot line 9", vec_out, 64'd1 << 33);
  endtask

  task automatic t_onboard_clear();
    clr_ob(10);
    chk("R11 wrong onboard line ignored", vec_out, 64'd1 << 33);
    clr_ob(1);
    chk("R11 exact onboard clear drops", vec_out, '0);
    idle();
    chk("R8 slot line before onboard", vec_out, m_pick());
  endtask

  task automatic t_pci_rise_clear();
    map_pci(0, 1); idle();
    chk("R7 request 9 kept", vec_out, 64'd1 << 9);
    set_irq(1, 1);
    chk("R5 slot rise takes over", vec_out, 64'd1 << 1);
    clr_pci(2);
    chk("R10 other slot clear ignored", vec_out, 64'd1 << 1);
    clr_pci(0);
    chk("R10 slot clear drops", vec_out, '0);
    idle();
    chk("R8 level line re-raised", vec_out, m_pick());
  endtask

  task automatic t_fall();
    set_irq(1, 0);
    chk("R12 fall keeps request", vec_out, 64'd1 << 1);
    clr_pci(0);
    chk("R10 slot 0 clear", vec_out, '0);
    idle();
    chk("R8 rescan to 9", vec_out, m_pick());
  endtask

  task automatic t_disable();
    map_pci(2, 0);
    chk("R9 disable drops slot request", vec_out, '0);
    idle();
    chk("R9 rescan after disable", vec_out, m_pick());
    map_ob(1, 0);
    chk("R9 disable drops onboard request", vec_out, '0);
    idle();
    chk("R8 nothing eligible", vec_out, m_pick());
  endtask

  task automatic t_onboard_rise();
    set_irq(40, 0);
    set_irq(33, 0);
    map_ob(8, 1); idle();
    chk("R6 idle before rise", vec_out, '0);
    set_irq(40, 1);
    chk("R6 onboard rise accepted", vec_out, 64'd1 << 40);
    map_ob(10, 1); idle();
    set_irq(42, 1);
    chk("R6 onboard rise refused while busy", vec_out, 64'd1 << 40);
    clr_ob(10);
    chk("R11 clear of pending line ignored", vec_out, 64'd1 << 40);
    clr_ob(8); idle();
    chk("R8 level onboard re-raised", vec_out, m_pick());
    set_irq(40, 0);
    chk("R12 onboard fall keeps request", vec_out, 64'd1 << 40);
    clr_ob(8); idle();
    chk("R8 next onboard picked", vec_out, 64'd1 << 42);
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    map_pci(3, 1); idle();
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears request", vec_out, '0);
    rst = 1'b0;
    m_en = '0;
    idle();
    chk("R1 no request after reset", vec_out, '0);
    bus_rd(32'h0C1C, d); chk("R1 enable cleared, code kept", 64'(d), 64'h7CC);
    bus_rd(32'h1054, d); chk("R1 onboard10 enable cleared", 64'(d), 64'h7EA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    t_reset_state();
    t_reg_access();
    t_gating();
    t_rescan_hold();
    t_onboard_clear();
    t_pci_rise_clear();
    t_fall();
    t_disable();
    t_onboard_rise();
    t_reset_again();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule